// File: doc/BRIEF.md
# FPGA configuration control sequencer

This block sits between a host register bus and the passive-parallel configuration port of a target FPGA. Software reads a status word that reports the configuration phase, the sampled mode-select pins and a few sticky flags, and writes a control word that enables the port, drives the chip enable, pulls the target's configuration-request line low, and picks the data width and clock-to-data ratio. The control word also opens or closes the data path.

Configuration words arrive on a separate write port. While the data path is open and the target is in its configuration phase, each word is driven onto a 16-bit or 32-bit parallel bus. Every DCLK pulse takes two core clocks, low then high. The phase follows the request line and the target's status and done inputs. After the last word, software issues a trailing run of DCLK pulses that moves the target into user mode.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset the status word reads phase 0 (power-up) and the control word reads 0x002. The request line and the chip enable are high, DCLK is low and the data bus is zero.
- R2: While control bit 0 (enable) is 0, the request line and the chip enable stay high, DCLK stays low and the data bus stays zero. The request bit cannot move the phase, and any transfer in progress stops.
- R3: With enable set, setting control bit 2 drives the request line low at once and moves the phase to 1 (reset) one cycle later. Once the bit is cleared, the phase moves to 2 (configuration) on the first cycle in which the target status input is high.
- R4: In configuration, a rising edge on the done input moves the phase to 3 (initialization). In phase 2 or 3, a low target status input moves the phase to 5 (unknown), and this check takes priority.
- R5: Status bits [7:3] show the mode-select pins one cycle after they change. Status bit 9 flags a mode mismatch in three cases: the code is unsupported (low two bits equal 3, or the code is above 0xE), control bit 9 (0 = 16-bit, 1 = 32-bit) differs from code bit 3, or control bits [7:6] differ from the required ratio. The required ratio is code bits [1:0] for a 16-bit code. For a 32-bit code it is 0, 2 or 3 for code bits [1:0] of 0, 1 or 2.
- R6: A data-port write is taken only when all of these hold: enable is set, control bit 8 (transfer) is set, the phase is 2, there is no mode mismatch and the serializer is idle. Any other data-port write is dropped and sets status bit 8. Status bit 8 stays set until a status write with bit 8 at 1.
- R7: In 32-bit mode an accepted word stays on the data bus for 2^ratio DCLK pulses. Each pulse is one core clock low and then one core clock high, and the first low clock follows the accepting edge.
- R8: In 16-bit mode an accepted word is sent as two beats of 2^ratio pulses each, bits [15:0] first and then bits [31:16], on data bus bits [15:0], with bits [31:16] of the bus held at zero.
- R9: A write of N (not 0) to offset 0x8 while the serializer is idle emits N DCLK pulses with a zero data bus. When the run ends, status bit 10 is set (a write of 1 to status bit 10 clears it), and a target in phase 3 moves to phase 4 (user mode).
- R10: Status bit 11 is high while pulses are being emitted. A data-port write in that time is dropped, sets status bit 8, and leaves the word on the bus unchanged.
- R11: The control word reads back with enable, chip enable, request, ratio, transfer and width at bits 0, 1, 2, [7:6], 8 and 9, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset (0x0 status, 0x4 control, 0x8 trailing count) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| dat_wr | input | 1 | Configuration word write strobe |
| dat_word | input | 32 | Configuration word |
| msel_pins | input | 5 | Mode-select pin code |
| tgt_nstatus | input | 1 | Target status, low on error or while in reset |
| tgt_conf_done | input | 1 | Target configuration done |
| cfg_nconfig_n | output | 1 | Configuration request to the target, active low |
| cfg_nce_n | output | 1 | Chip enable to the target, active low |
| cfg_dclk | output | 1 | Data clock to the target |
| cfg_data | output | 32 | Parallel configuration data |

## Verification
The bench builds the block with its default trailing-count width of 16 bits, which covers every word length: a 16-bit word at ratio x4 takes 8 pulses and a 32-bit word at x8 takes 8 pulses. Mode checks walk all 32 mode-select codes and then draw random codes against random width and ratio settings. The serializer is driven with random words in random supported modes, and its output is checked cycle by cycle against the expected low-high pulse pattern and beat order. Directed cases cover drops while the block is disabled, busy or outside the configuration phase, the trailing run into user mode, and the error exit to the unknown phase.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam int unsigned MSEL_W = 5;

  localparam logic [3:0] OFS_STAT  = 4'h0;
  localparam logic [3:0] OFS_CTL   = 4'h4;
  localparam logic [3:0] OFS_TRAIL = 4'h8;

  typedef enum logic [2:0] {
    PH_PWRUP   = 3'd0,
    PH_RESET   = 3'd1,
    PH_CFG     = 3'd2,
    PH_INIT    = 3'd3,
    PH_USER    = 3'd4,
    PH_UNKNOWN = 3'd5
  } phase_e;

  typedef struct packed {
    logic       wide;
    logic       xfer;
    logic [1:0] ratio;
    logic       pull;
    logic       nce;
    logic       en;
  } ctl_t;

  function automatic logic mode_supported(input logic [MSEL_W-1:0] code);
    return (code <= 5'h0E) && (code[1:0] != 2'b11);
  endfunction

  function automatic logic [1:0] req_ratio(input logic [MSEL_W-1:0] code);
    logic [1:0] r;
    if (!code[3])               r = code[1:0];
    else if (code[1:0] == 2'd0) r = 2'd0;
    else                        r = 2'(code[1:0] + 2'd1);
    return r;
  endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [MSEL_W-1:0] msel_pins,
  input  phase_e            phase,
  input  logic              busy,
  input  logic              drop,
  input  logic              trail_done,
  output ctl_t              ctl,
  output logic              mode_bad,
  output logic              trail_wr,
  output logic [CNT_W-1:0]  trail_n
);

  ctl_t              ctl_q, ctl_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [MSEL_W-1:0] msel_q;
  logic              wr_stat, wr_ctl;
  logic              unused_bits;

  assign wr_stat     = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ctl      = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign trail_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_TRAIL));
  assign trail_n     = bus_wdata[CNT_W-1:0];
  assign unused_bits = ^bus_wdata;

  always_comb begin
    ctl_d  = ctl_q;
    err_d  = err_q;
    done_d = done_q;
    if (wr_ctl) begin
      ctl_d.en    = bus_wdata[0];
      ctl_d.nce   = bus_wdata[1];
      ctl_d.pull  = bus_wdata[2];
      ctl_d.ratio = bus_wdata[7:6];
      ctl_d.xfer  = bus_wdata[8];
      ctl_d.wide  = bus_wdata[9];
    end
    if (wr_stat && bus_wdata[8])  err_d  = 1'b0;
    if (wr_stat && bus_wdata[10]) done_d = 1'b0;
    if (drop)       err_d  = 1'b1;
    if (trail_done) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{wide: 1'b0, xfer: 1'b0, ratio: 2'd0, pull: 1'b0, nce: 1'b1, en: 1'b0};
      err_q  <= 1'b0;
      done_q <= 1'b0;
      msel_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      err_q  <= err_d;
      done_q <= done_d;
      msel_q <= msel_pins;
    end
  end

  assign ctl = ctl_q;
  assign mode_bad = !mode_supported(msel_q) || (ctl_q.wide != msel_q[3]) ||
                    (ctl_q.ratio != req_ratio(msel_q));

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_STAT): bus_rdata = {20'd0, busy, done_q, mode_bad, err_q, msel_q, phase};
      ADDR_W'(OFS_CTL):  bus_rdata = {22'd0, ctl_q.wide, ctl_q.xfer, ctl_q.ratio, 3'd0,
                                      ctl_q.pull, ctl_q.nce, ctl_q.en};
      default:           bus_rdata = 32'd0;
    endcase
  end

  // R6: a dropped data write raises the flag; it is held until cleared
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n) drop |=> err_q);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr_stat && bus_wdata[8]) |=> err_q);
  // R9: end of a trailing run raises the done flag
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n) trail_done |=> done_q);

endmodule

// File: rtl/cfg_phase.sv
module cfg_phase
  import cfgseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pull_eff,
  input  logic   nstatus,
  input  logic   conf_done,
  input  logic   trail_done,
  output phase_e phase
);

  phase_e ph_q, ph_d;
  logic   cdone_q;

  always_comb begin
    ph_d = ph_q;
    if (pull_eff) begin
      ph_d = PH_RESET;
    end else begin
      case (ph_q)
        PH_RESET: if (nstatus) ph_d = PH_CFG;
        PH_CFG: begin
          if (!nstatus)                    ph_d = PH_UNKNOWN;
          else if (conf_done && !cdone_q)  ph_d = PH_INIT;
        end
        PH_INIT: begin
          if (!nstatus)        ph_d = PH_UNKNOWN;
          else if (trail_done) ph_d = PH_USER;
        end
        default: ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_PWRUP;
      cdone_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cdone_q <= conf_done;
    end
  end

  assign phase = ph_q;

  // R3: request bit moves the phase to reset
  p_reset_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_eff |=> phase == PH_RESET);
  // R4: done rising in configuration enters initialization
  p_init_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CFG) && !pull_eff && nstatus && conf_done && !cdone_q |=> phase == PH_INIT);
  p_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CFG) || (phase == PH_INIT)) && !pull_eff && !nstatus |=> phase == PH_UNKNOWN);
  // R9: trailing run completion enters user mode
  p_user_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT) && !pull_eff && nstatus && trail_done |=> phase == PH_USER);

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wide,
  input  logic [1:0]       ratio,
  input  logic             may_accept,
  input  logic             dat_wr,
  input  logic [31:0]      dat_word,
  input  logic             trail_wr,
  input  logic [CNT_W-1:0] trail_n,
  output logic             busy,
  output logic             dclk,
  output logic [31:0]      data,
  output logic             drop,
  output logic             trail_done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pulses_q, pulses_d;
  logic             tg_q, tg_d;
  logic [31:0]      word_q, word_d;
  logic             narrow_q, narrow_d;
  logic [1:0]       ratio_q, ratio_d;
  logic             trail_q, trail_d;
  logic             accept, trail_go, second;
  logic [CNT_W-1:0] beat_len, word_len, cur_beat;

  assign busy       = (pulses_q != '0);
  assign accept     = en && may_accept && !busy && dat_wr;
  assign drop       = dat_wr && !accept;
  assign trail_go   = en && !busy && !accept && trail_wr && (trail_n != '0);
  assign trail_done = en && busy && tg_q && (pulses_q == ONE) && trail_q;
  assign beat_len   = ONE << ratio;
  assign word_len   = wide ? beat_len : (beat_len << 1);
  assign cur_beat   = ONE << ratio_q;

  always_comb begin
    pulses_d = pulses_q;
    tg_d     = tg_q;
    word_d   = word_q;
    narrow_d = narrow_q;
    ratio_d  = ratio_q;
    trail_d  = trail_q;
    if (!en) begin
      pulses_d = '0;
      tg_d     = 1'b0;
    end else if (busy) begin
      if (tg_q) begin
        tg_d     = 1'b0;
        pulses_d = pulses_q - ONE;
      end else begin
        tg_d = 1'b1;
      end
    end else if (accept) begin
      pulses_d = word_len;
      tg_d     = 1'b0;
      word_d   = dat_word;
      narrow_d = !wide;
      ratio_d  = ratio;
      trail_d  = 1'b0;
    end else if (trail_go) begin
      pulses_d = trail_n;
      tg_d     = 1'b0;
      word_d   = '0;
      narrow_d = 1'b0;
      trail_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses_q <= '0;
      tg_q     <= 1'b0;
      word_q   <= '0;
      narrow_q <= 1'b0;
      ratio_q  <= '0;
      trail_q  <= 1'b0;
    end else begin
      pulses_q <= pulses_d;
      tg_q     <= tg_d;
      word_q   <= word_d;
      narrow_q <= narrow_d;
      ratio_q  <= ratio_d;
      trail_q  <= trail_d;
    end
  end

  assign second = narrow_q && (pulses_q <= cur_beat);
  assign dclk   = busy && tg_q;

  always_comb begin
    if (!busy)         data = '0;
    else if (!narrow_q) data = word_q;
    else if (second)    data = {16'd0, word_q[31:16]};
    else                data = {16'd0, word_q[15:0]};
  end

  // R2: clearing enable stops any run
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !busy);
  // R7: word held on the bus through the whole run
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(tg_q && (pulses_q == ONE)) |=> $stable(word_q));
  // R10: a write while busy leaves the current word in place
  p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_wr |=> $stable(word_q));

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfgseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dat_wr,
  input  logic [31:0]       dat_word,
  input  logic [4:0]        msel_pins,
  input  logic              tgt_nstatus,
  input  logic              tgt_conf_done,
  output logic              cfg_nconfig_n,
  output logic              cfg_nce_n,
  output logic              cfg_dclk,
  output logic [31:0]       cfg_data
);

  ctl_t             ctl;
  phase_e           phase;
  logic             mode_bad, busy, drop, trail_done, trail_wr;
  logic [CNT_W-1:0] trail_n;
  logic             sh_dclk, may_accept, pull_eff;
  logic [31:0]      sh_data;

  assign pull_eff   = ctl.en && ctl.pull;
  assign may_accept = ctl.xfer && (phase == PH_CFG) && !mode_bad;

  cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msel_pins(msel_pins),
    .phase(phase), .busy(busy), .drop(drop), .trail_done(trail_done),
    .ctl(ctl), .mode_bad(mode_bad), .trail_wr(trail_wr), .trail_n(trail_n)
  );

  cfg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .pull_eff(pull_eff), .nstatus(tgt_nstatus),
    .conf_done(tgt_conf_done), .trail_done(trail_done), .phase(phase)
  );

  cfg_shift #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .wide(ctl.wide), .ratio(ctl.ratio),
    .may_accept(may_accept), .dat_wr(dat_wr), .dat_word(dat_word),
    .trail_wr(trail_wr), .trail_n(trail_n), .busy(busy), .dclk(sh_dclk),
    .data(sh_data), .drop(drop), .trail_done(trail_done)
  );

  assign cfg_nconfig_n = !pull_eff;
  assign cfg_nce_n     = ctl.en ? ctl.nce : 1'b1;
  assign cfg_dclk      = ctl.en && sh_dclk;
  assign cfg_data      = ctl.en ? sh_data : 32'd0;

  // R2: idle levels whenever the port is disabled
  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> cfg_nconfig_n && cfg_nce_n && !cfg_dclk && (cfg_data == 32'd0));
  // R6: nothing is accepted outside the configuration phase
  p_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && (phase != PH_CFG) |-> drop);

endmodule

// File: tb/sim_cfg_seq_top.sv
module sim_cfg_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        dat_wr;
  logic [31:0] dat_word;
  logic [4:0]  msel_pins;
  logic        tgt_nstatus, tgt_conf_done;
  logic        cfg_nconfig_n, cfg_nce_n, cfg_dclk;
  logic [31:0] cfg_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dat_wr(dat_wr),
    .dat_word(dat_word), .msel_pins(msel_pins), .tgt_nstatus(tgt_nstatus),
    .tgt_conf_done(tgt_conf_done), .cfg_nconfig_n(cfg_nconfig_n),
    .cfg_nce_n(cfg_nce_n), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [1:0] exp_ratio(input logic [4:0] c);
    if (!c[3]) return c[1:0];
    if (c[1:0] == 2'd0) return 2'd0;
    return 2'(c[1:0] + 2'd1);
  endfunction

  function automatic logic exp_bad(input logic [4:0] c, input logic w, input logic [1:0] r);
    logic ok;
    ok = (c <= 5'h0E) && (c[1:0] != 2'b11);
    return !ok || (w != c[3]) || (r != exp_ratio(c));
  endfunction

  function automatic logic [31:0] ctl_word(input logic en, input logic nce, input logic pull,
                                           input logic [1:0] r, input logic xf, input logic w);
    return {22'd0, w, xf, r, 3'd0, pull, nce, en};
  endfunction

  // send a word and compare the pulse pattern and beats sample by sample
  task automatic send(input logic [31:0] w32, input logic wide, input logic [1:0] r);
    int plen, mism;
    logic [31:0] exp_d, st;
    plen = (1 << r) * (wide ? 1 : 2);
    mism = 0;
    dat_wr = 1'b1; dat_word = w32;
    tick();
    dat_wr = 1'b0;
    for (int c = 0; c < 2 * plen; c++) begin
      if (wide)                exp_d = w32;
      else if (c / 2 < (1 << r)) exp_d = {16'd0, w32[15:0]};
      else                      exp_d = {16'd0, w32[31:16]};
      if (cfg_dclk !== 1'(c % 2) || cfg_data !== exp_d) mism++;
      tick();
    end
    chk(wide ? "R7 pulse pattern 32-bit" : "R8 beat order 16-bit", 32'(mism), 32'd0);
    rd(4'h0, st);
    chk("R10 busy clear after word", {31'd0, st[11]}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7351));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
    dat_wr = 1'b0; dat_word = 32'd0; msel_pins = 5'd0;
    tgt_nstatus = 1'b0; tgt_conf_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(4'h0, v); chk("R1 status after reset", v, 32'd0);
    rd(4'h4, v); chk("R1 control after reset", v, 32'h002);
    chk("R1 idle pins", {cfg_nconfig_n, cfg_nce_n, cfg_dclk}, 3'b110);
    chk("R1 data idle", cfg_data, 32'd0);

    // R2 disabled: request ignored, data write dropped
    wr(4'h4, ctl_word(0, 0, 1, 2'd0, 1, 0));
    chk("R2 request held high when disabled", {31'd0, cfg_nconfig_n}, 32'd1);
    chk("R2 chip enable high when disabled", {31'd0, cfg_nce_n}, 32'd1);
    rd(4'h4, v); chk("R11 control readback", v, 32'h104);
    tick();
    rd(4'h0, v); chk("R2 phase unchanged", {29'd0, v[2:0]}, 32'd0);
    dat_wr = 1'b1; dat_word = 32'hDEAD_BEEF; tick(); dat_wr = 1'b0;
    rd(4'h0, v); chk("R6 drop while disabled sets flag", {31'd0, v[8]}, 32'd1);
    chk("R2 data stays zero", cfg_data, 32'd0);
    wr(4'h0, 32'h100);
    rd(4'h0, v); chk("R6 flag cleared by write", {31'd0, v[8]}, 32'd0);

    // R5 all codes against a fixed setting
    wr(4'h4, ctl_word(0, 1, 0, 2'd0, 0, 0));
    for (int c = 0; c < 32; c++) begin
      msel_pins = 5'(c);
      tick();
      rd(4'h0, v);
      chk("R5 pins in status", {27'd0, v[7:3]}, 32'(c));
      chk("R5 mismatch flag", {31'd0, v[9]}, {31'd0, exp_bad(5'(c), 1'b0, 2'd0)});
    end
    for (int i = 0; i < 24; i++) begin
      logic [4:0] c; logic w; logic [1:0] r;
      c = 5'($urandom); w = 1'($urandom); r = 2'($urandom);
      msel_pins = c;
      wr(4'h4, ctl_word(0, 1, 0, r, 0, w));
      rd(4'h0, v);
      chk("R5 random mismatch flag", {31'd0, v[9]}, {31'd0, exp_bad(c, w, r)});
    end

    // R3 / R4 reset entry and held reset while status is low
    msel_pins = 5'h0;
    wr(4'h4, ctl_word(1, 0, 1, 2'd0, 0, 0));
    chk("R3 request low at once", {31'd0, cfg_nconfig_n}, 32'd0);
    tick();
    rd(4'h0, v); chk("R3 phase reset", {29'd0, v[2:0]}, 32'd1);
    wr(4'h4, ctl_word(1, 0, 0, 2'd0, 0, 0));
    tick();
    rd(4'h0, v); chk("R3 stays in reset while status low", {29'd0, v[2:0]}, 32'd1);
    tgt_nstatus = 1'b1;
    tick();
    rd(4'h0, v); chk("R3 configuration phase", {29'd0, v[2:0]}, 32'd2);

    // R6 transfer disabled in configuration
    dat_wr = 1'b1; dat_word = 32'h1234_5678; tick(); dat_wr = 1'b0;
    rd(4'h0, v); chk("R6 drop with transfer off", {19'd0, v[11], 3'd0, v[8]}, 32'h1);
    wr(4'h0, 32'h100);
    // R6 mode mismatch blocks accept
    msel_pins = 5'h08;
    wr(4'h4, ctl_word(1, 0, 0, 2'd0, 1, 0));
    dat_wr = 1'b1; tick(); dat_wr = 1'b0;
    rd(4'h0, v); chk("R6 drop on mode mismatch", {19'd0, v[11], 3'd0, v[8]}, 32'h1);
    wr(4'h0, 32'h100);

    // R7 / R8 directed corners
    msel_pins = 5'h0A;
    wr(4'h4, ctl_word(1, 0, 0, 2'd3, 1, 1));
    send(32'hA5A5_0F0F, 1'b1, 2'd3);
    msel_pins = 5'h00;
    wr(4'h4, ctl_word(1, 0, 0, 2'd0, 1, 0));
    send(32'hCAFE_1234, 1'b0, 2'd0);

    // R7 / R8 random modes and words
    for (int i = 0; i < 24; i++) begin
      logic w; logic b2; logic [1:0] s; logic [4:0] c; logic [1:0] r;
      w = 1'($urandom); b2 = 1'($urandom); s = 2'($urandom % 3);
      c = {1'b0, w, b2, s};
      r = exp_ratio(c);
      msel_pins = c;
      wr(4'h4, ctl_word(1, 0, 0, r, 1, w));
      send($urandom, w, r);
    end
    rd(4'h0, v); chk("R6 no drop on valid sends", {31'd0, v[8]}, 32'd0);

    // R10 write while busy
    msel_pins = 5'h0A;
    wr(4'h4, ctl_word(1, 0, 0, 2'd3, 1, 1));
    dat_wr = 1'b1; dat_word = 32'h1111_2222; tick(); dat_wr = 1'b0;
    tick(); tick();
    rd(4'h0, v); chk("R10 busy flag", {31'd0, v[11]}, 32'd1);
    dat_wr = 1'b1; dat_word = 32'h3333_4444; tick(); dat_wr = 1'b0;
    rd(4'h0, v); chk("R10 busy write dropped", {31'd0, v[8]}, 32'd1);
    chk("R10 word unchanged", cfg_data, 32'h1111_2222);
    repeat (16) tick();
    chk("R10 run ended", {31'd0, cfg_dclk}, 32'd0);
    wr(4'h0, 32'h100);

    // R4 done rise, R9 trailing run
    tgt_conf_done = 1'b1;
    tick();
    rd(4'h0, v); chk("R4 initialization phase", {29'd0, v[2:0]}, 32'd3);
    wr(4'h8, 32'd4);
    begin
      int mism = 0;
      for (int c = 0; c < 8; c++) begin
        if (cfg_dclk !== 1'(c % 2) || cfg_data !== 32'd0) mism++;
        if (c == 7) begin
          rd(4'h0, v); chk("R9 still initializing", {29'd0, v[2:0]}, 32'd3);
        end
        tick();
      end
      chk("R9 trailing pulses", 32'(mism), 32'd0);
    end
    rd(4'h0, v);
    chk("R9 user mode", {29'd0, v[2:0]}, 32'd4);
    chk("R9 done flag", {31'd0, v[10]}, 32'd1);
    wr(4'h0, 32'h400);
    rd(4'h0, v); chk("R9 done cleared", {31'd0, v[10]}, 32'd0);
    dat_wr = 1'b1; tick(); dat_wr = 1'b0;
    rd(4'h0, v); chk("R6 drop in user mode", {31'd0, v[8]}, 32'd1);

    // R4 status low in configuration
    tgt_conf_done = 1'b0;
    wr(4'h4, ctl_word(1, 0, 1, 2'd0, 0, 0));
    tick();
    wr(4'h4, ctl_word(1, 0, 0, 2'd0, 0, 0));
    tick();
    rd(4'h0, v); chk("R4 back in configuration", {29'd0, v[2:0]}, 32'd2);
    tgt_nstatus = 1'b0;
    tick();
    rd(4'h0, v); chk("R4 unknown on status low", {29'd0, v[2:0]}, 32'd5);

    // R2 disable mid-run stops pulses
    tgt_nstatus = 1'b1;
    wr(4'h8, 32'd20);
    wr(4'h4, ctl_word(0, 0, 0, 2'd0, 0, 0));
    tick();
    wr(4'h4, ctl_word(1, 0, 0, 2'd0, 0, 0));
    rd(4'h0, v); chk("R2 run stopped by disable", {31'd0, v[11]}, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule